// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable stand-in for a parallel NOR flash part that takes its commands as bytes written over the bus. It has a synchronous slave port with a byte address, write data, a write strobe, a read strobe and registered read data. A write-cycle state machine reads the low byte of each write. Depending on the command in progress, that byte starts a sequence, completes a sequence, or stores data into a small sector-organized array.

The state machine also decides what reads return. A read gives array contents, the 8-bit status register, or one byte of a fixed query table. The supported operations are:
- whole-sector erase behind a confirm byte,
- counted buffered programming,
- status clear and status read,
- query mode,
- acceptance of lock/unlock sequences,
- return to array reads.

Erase and programming finish in the cycle of the write that triggers them. There is no busy period.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the device is in array mode, the status register holds 0x80, and each array byte holds the low 8 bits of its own byte address.
- R2: In array mode, a read returns its data on `rdata` one cycle after `rd_en`. The word is assembled little-endian: byte at `addr+k` goes to bits `8k+7:8k`.
- R3: A write of 0x70 selects status reads, and every read then returns the status register zero-extended. In array or status mode, a write of 0xFF, 0x00 or any unlisted byte selects array reads and leaves storage unchanged.
- R4: A write of 0x50 in array or status mode clears the status register to 0x00 and selects array reads.
- R5: A write of 0x20 arms an erase, and reads return status while it is armed. A following write of 0xD0 fills the whole sector containing that write's address with 0xFF, sets status bit 7 and selects array reads. The sector is the address with its low log2(sector bytes) bits dropped.
- R6: In the armed-erase state, any write other than 0xD0 selects array reads without erasing and without touching status.
- R7: A write of 0xE8 sets status bit 7 and starts a buffer sequence. The next write carries a count N in its low byte. The following N+1 writes store their full words little-endian at their own addresses. A final 0xD0 returns to array reads. Reads return status throughout the sequence.
- R8: A write other than 0xD0 in the buffer-confirm slot returns to array reads and stores nothing.
- R9: A write of 0x60 arms a lock sequence. A following 0xD0 or 0x01 sets status bit 7. Any other byte leaves status alone. Either way the device selects array reads and no storage changes.
- R10: A write of 0x98 selects query reads. The table index is the byte address divided by the bus width in bytes, and the byte is zero-extended on `rdata`. Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59. Index 0x13 holds 0x01, and index 0x2D holds the sector count minus one. Indices at or above 0x52 read 0.
- R11: In query mode, only 0xFF or 0x00 leaves to array reads; other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8*BUS_BYTES | Write data; low byte is the command byte |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe; data valid on the next cycle |
| rdata | output | 8*BUS_BYTES | Registered read data |

## Verification
The bench checks that erase stays inside the addressed sector by reading the words just below and just above its bounds. A design that mis-masks the address would wipe a neighbour or leave part of the sector intact.

It runs a buffer sequence with a count of one, expecting exactly two stored words. An off-by-one counter would store one word too few, or swallow the confirm byte as data.

Aborted erase, aborted lock and a bad buffer confirm are each followed by array and status reads. Any stray write or spurious ready bit would show up there.

In query mode the bench reads past the table end and writes a non-exit command. A design that wraps the index or leaves on any write would return the wrong byte.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        MD_ARRAY,
        MD_STATUS,
        MD_ERASE_ARM,
        MD_LOCK_ARM,
        MD_QUERY,
        MD_BUF_COUNT,
        MD_BUF_DATA,
        MD_BUF_CLOSE
    } fl_mode_e;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_STATUS,
        SRC_QUERY
    } rd_src_e;

    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_CLEAR     = 8'h50;
    localparam logic [7:0] OP_LOCK      = 8'h60;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_QUERY     = 8'h98;
    localparam logic [7:0] OP_BUFFER    = 8'hE8;
    localparam logic [7:0] OP_READ_ARR  = 8'hFF;
    localparam logic [7:0] OP_NULL      = 8'h00;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT  = 8'h01;
    localparam logic [7:0] STAT_READY   = 8'h80;
    localparam int         QRY_LEN      = 82;

    // Query table contents, indexed by table slot.
    function automatic logic [7:0] qry_byte(input int idx, input int log2_total,
                                            input int nsec, input int sec_bytes);
        logic [15:0] nm1;
        logic [31:0] sb;
        nm1 = 16'(nsec - 1);
        sb  = 32'(sec_bytes);
        case (idx)
            16: return 8'h51;
            17: return 8'h52;
            18: return 8'h59;
            19: return 8'h01;
            21: return 8'h31;
            27: return 8'h45;
            28: return 8'h55;
            31: return 8'h07;
            32: return 8'h07;
            33: return 8'h0A;
            35: return 8'h04;
            36: return 8'h04;
            37: return 8'h04;
            39: return 8'(log2_total);
            40: return 8'h02;
            42: return 8'h04;
            44: return 8'h01;
            45: return nm1[7:0];
            46: return nm1[15:8];
            47: return sb[15:8];
            48: return sb[23:16];
            49: return 8'h50;
            50: return 8'h52;
            51: return 8'h49;
            52: return 8'h31;
            53: return 8'h31;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flash_query_rom.sv
module flash_query_rom
    import flash_pkg::*;
#(
    parameter int IDX_W        = 7,
    parameter int LOG2_TOTAL   = 8,
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_BYTES = 64
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       q
);
    localparam int ROM_W = $clog2(QRY_LEN);

    logic [7:0] rom [QRY_LEN];

    for (genvar g = 0; g < QRY_LEN; g++) begin : g_rom
        assign rom[g] = qry_byte(g, LOG2_TOTAL, NUM_SECTORS, SECTOR_BYTES);
    end

    logic [ROM_W-1:0] ridx;

    always_comb begin
        ridx = ROM_W'(idx);
        if (int'(idx) < QRY_LEN) q = rom[ridx];
        else                     q = 8'h00;
    end
endmodule

// File: rtl/flash_store.sv
module flash_store #(
    parameter int ADDR_W       = 8,
    parameter int BUS_BYTES    = 2,
    parameter int SECTOR_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   erase_go,
    input  logic                   prog_go,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [8*BUS_BYTES-1:0] wdata,
    output logic [8*BUS_BYTES-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SEC_W = $clog2(SECTOR_BYTES);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i);
        end else if (erase_go) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((ADDR_W'(i) >> SEC_W) == (addr >> SEC_W)) mem[i] <= 8'hFF;
            end
        end else if (prog_go) begin
            for (int k = 0; k < BUS_BYTES; k++) begin
                mem[addr + ADDR_W'(k)] <= wdata[8*k +: 8];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < BUS_BYTES; k++) begin
            rd_word[8*k +: 8] = mem[addr + ADDR_W'(k)];
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] cmd,
    output fl_mode_e   mode,
    output logic [7:0] status,
    output logic       erase_go,
    output logic       prog_go
);
    fl_mode_e   mode_n;
    logic [7:0] stat_n;
    logic [7:0] cnt, cnt_n;

    always_comb begin
        mode_n   = mode;
        stat_n   = status;
        cnt_n    = cnt;
        erase_go = 1'b0;
        prog_go  = 1'b0;
        if (wr_en) begin
            case (mode)
                MD_ARRAY, MD_STATUS: begin
                    case (cmd)
                        OP_ERASE:  mode_n = MD_ERASE_ARM;
                        OP_CLEAR: begin
                            stat_n = 8'h00;
                            mode_n = MD_ARRAY;
                        end
                        OP_LOCK:   mode_n = MD_LOCK_ARM;
                        OP_STATUS: mode_n = MD_STATUS;
                        OP_QUERY:  mode_n = MD_QUERY;
                        OP_BUFFER: begin
                            stat_n = status | STAT_READY;
                            mode_n = MD_BUF_COUNT;
                        end
                        default:   mode_n = MD_ARRAY;
                    endcase
                end
                MD_ERASE_ARM: begin
                    if (cmd == OP_CONFIRM) begin
                        erase_go = 1'b1;
                        stat_n   = status | STAT_READY;
                    end
                    mode_n = MD_ARRAY;
                end
                MD_LOCK_ARM: begin
                    if (cmd == OP_CONFIRM || cmd == OP_LOCK_ALT)
                        stat_n = status | STAT_READY;
                    mode_n = MD_ARRAY;
                end
                MD_QUERY: begin
                    if (cmd == OP_READ_ARR || cmd == OP_NULL) mode_n = MD_ARRAY;
                end
                MD_BUF_COUNT: begin
                    cnt_n  = cmd;
                    mode_n = MD_BUF_DATA;
                end
                MD_BUF_DATA: begin
                    prog_go = 1'b1;
                    stat_n  = status | STAT_READY;
                    if (cnt == 8'd0) mode_n = MD_BUF_CLOSE;
                    else             cnt_n  = cnt - 8'd1;
                end
                MD_BUF_CLOSE: begin
                    if (cmd == OP_CONFIRM) stat_n = status | STAT_READY;
                    mode_n = MD_ARRAY;
                end
                default: mode_n = MD_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MD_ARRAY;
            status <= STAT_READY;
            cnt    <= 8'd0;
        end else begin
            mode   <= mode_n;
            status <= stat_n;
            cnt    <= cnt_n;
        end
    end
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
    import flash_pkg::*;
#(
    parameter int BUS_BYTES    = 2,
    parameter int SECTOR_BYTES = 64,
    parameter int NUM_SECTORS  = 4,
    localparam int DATA_W      = 8 * BUS_BYTES,
    localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS,
    localparam int ADDR_W      = $clog2(TOTAL_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int BSH   = $clog2(BUS_BYTES);
    localparam int IDX_W = ADDR_W - BSH;

    fl_mode_e          mode;
    logic [7:0]        status;
    logic              erase_go, prog_go;
    logic [DATA_W-1:0] arr_word;
    logic [7:0]        qry_q;
    rd_src_e           src;

    flash_cmd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .cmd      (wdata[7:0]),
        .mode     (mode),
        .status   (status),
        .erase_go (erase_go),
        .prog_go  (prog_go)
    );

    flash_store #(
        .ADDR_W       (ADDR_W),
        .BUS_BYTES    (BUS_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .erase_go (erase_go),
        .prog_go  (prog_go),
        .addr     (addr),
        .wdata    (wdata),
        .rd_word  (arr_word)
    );

    flash_query_rom #(
        .IDX_W        (IDX_W),
        .LOG2_TOTAL   (ADDR_W),
        .NUM_SECTORS  (NUM_SECTORS),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_qry (
        .idx (addr[ADDR_W-1:BSH]),
        .q   (qry_q)
    );

    always_comb begin
        case (mode)
            MD_ARRAY: src = SRC_ARRAY;
            MD_QUERY: src = SRC_QUERY;
            default:  src = SRC_STATUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (src)
                SRC_ARRAY: rdata <= arr_word;
                SRC_QUERY: rdata <= DATA_W'(qry_q);
                default:   rdata <= DATA_W'(status);
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk
    import flash_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input fl_mode_e          mode,
    input logic [7:0]        status
);
    // R3
    status_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mode != MD_ARRAY && mode != MD_QUERY) |=> rdata == DATA_W'($past(status)));

    // R4
    clear_status_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (mode == MD_ARRAY || mode == MD_STATUS) && wdata[7:0] == OP_CLEAR)
        |=> (status == 8'h00 && mode == MD_ARRAY));

    // R5
    erase_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MD_ERASE_ARM && wdata[7:0] == OP_CONFIRM)
        |=> (status[7] && mode == MD_ARRAY));

    // R6
    erase_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MD_ERASE_ARM && wdata[7:0] != OP_CONFIRM)
        |=> (mode == MD_ARRAY && $stable(status)));

    // R7
    buf_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MD_BUF_COUNT) |=> mode == MD_BUF_DATA);

    // R9
    lock_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MD_LOCK_ARM) |=> mode == MD_ARRAY);

    // R11
    query_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MD_QUERY && wdata[7:0] != OP_READ_ARR && wdata[7:0] != OP_NULL)
        |=> mode == MD_QUERY);
endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .mode   (mode),
    .status (status)
);

// File: tb/nor_cmd_flash_bench.sv
`timescale 1ns/1ps
module nor_cmd_flash_bench;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    logic          rd_q = 1'b0;
    logic [DW-1:0] exp_q [$];
    string         req_q [$];

    always #2.5 clk = ~clk;

    nor_cmd_flash u_nor_cmd_flash (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    always_ff @(posedge clk) rd_q <= rd_en;

    // Monitor: compares each registered read against the next queued expectation.
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", r, rdata, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string r);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        req_q.push_back(r);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2: reset contents, little-endian word
        rd(8'h04, 16'h0504, "R1");
        rd(8'h11, 16'h1211, "R2");
        // R1 R3: status holds ready after reset
        wr(8'h00, 16'h0070);
        rd(8'h04, 16'h0080, "R1");
        rd(8'h90, 16'h0080, "R3");
        wr(8'h00, 16'h00FF);
        rd(8'h10, 16'h1110, "R3");

        // R4: clear status, back to array
        wr(8'h00, 16'h0050);
        rd(8'h20, 16'h2120, "R4");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R4");
        wr(8'h00, 16'h0000);

        // R5: erase sector 1 (0x40..0x7F)
        wr(8'h45, 16'h0020);
        rd(8'h45, 16'h0000, "R5");
        wr(8'h45, 16'h00D0);
        rd(8'h40, 16'hFFFF, "R5");
        rd(8'h7E, 16'hFFFF, "R5");
        rd(8'h3E, 16'h3F3E, "R5");
        rd(8'h80, 16'h8180, "R5");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0080, "R5");

        // R6: aborted erase
        wr(8'h00, 16'h0050);
        wr(8'h85, 16'h0020);
        wr(8'h85, 16'h0033);
        rd(8'h84, 16'h8584, "R6");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R6");
        wr(8'h00, 16'h00FF);

        // R7: buffer sequence with count 1 (two data words)
        wr(8'hC0, 16'h00E8);
        rd(8'hC0, 16'h0080, "R7");
        wr(8'hC0, 16'h0001);
        wr(8'hC0, 16'hBEEF);
        rd(8'hC0, 16'h0080, "R7");
        wr(8'hC2, 16'h1234);
        wr(8'hC0, 16'h00D0);
        rd(8'hC0, 16'hBEEF, "R7");
        rd(8'hC2, 16'h1234, "R7");
        rd(8'hC4, 16'hC5C4, "R7");

        // R8: bad confirm stores nothing
        wr(8'hD0, 16'h00E8);
        wr(8'hD0, 16'h0000);
        wr(8'hD0, 16'hAAAA);
        wr(8'hD2, 16'h5555);
        rd(8'hD2, 16'hD3D2, "R8");
        rd(8'hD0, 16'hAAAA, "R8");

        // R9: lock with 0x01 sets ready; bad second byte does not
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h0001);
        rd(8'h00, 16'h0100, "R9");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0080, "R9");
        wr(8'h00, 16'h0050);
        wr(8'h10, 16'h0060);
        wr(8'h10, 16'h0042);
        rd(8'h10, 16'h1110, "R9");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R9");

        // R10 R11: query table
        wr(8'h00, 16'h0098);
        rd(8'h20, 16'h0051, "R10");
        rd(8'h22, 16'h0052, "R10");
        rd(8'h24, 16'h0059, "R10");
        rd(8'h26, 16'h0001, "R10");
        rd(8'h5A, 16'h0003, "R10");
        rd(8'hA4, 16'h0000, "R10");
        wr(8'h00, 16'h0070);
        rd(8'h20, 16'h0051, "R11");
        wr(8'h00, 16'h00FF);
        rd(8'h20, 16'h2120, "R11");

        // R3: unlisted command byte is not stored
        wr(8'h30, 16'h0037);
        rd(8'h30, 16'h3130, "R3");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule